// File: doc/BRIEF.md
# Serial Receiver with Line-Break Handling

This block turns an asynchronous serial line into a queue of received characters. The line is examined on a sample-enable pulse that runs at sixteen times the bit rate. A falling edge is treated as a possible start bit, and it is confirmed only at the middle of that bit. Each character can have five to eight data bits, an optional even or odd parity bit, and one or two stop bits. Every finished character goes into a sixteen-entry queue. Each queue entry holds the data byte together with its own parity-error, framing-error and break tags.

When the line stays low for longer than one whole character time at the current settings, the block records a break. A break places one zero character in the queue, however long the low level lasts. After a break, the receiver waits until it has seen the line high on two consecutive samples, and only then looks for a new start bit.

The tags of an entry reach the status port only when that entry becomes the oldest one in the queue. The status bits then hold their value until the next status read clears them.

Top module: `serial_rx_brk`

## Requirements
- R1: `cfg_len` selects 5, 6, 7 or 8 data bits (codes 0 to 3). Data bits arrive least significant bit first. The received character appears on `rx_data` right-aligned, with the unused upper bits set to zero.
- R2: When `cfg_par_en` is 1, a parity bit follows the data bits. With `cfg_par_odd` = 0 the data bits plus the parity bit must hold an even number of ones; with `cfg_par_odd` = 1 they must hold an odd number. A mismatch sets the parity tag of that entry.
- R3: A stop bit that samples low sets the framing tag of the entry. With `cfg_two_stop` = 1, both stop bits are checked.
- R4: The block declares a break when the line stays low for more than (1 + data bits + parity bit + stop bits) × 16 sample ticks. A break pushes exactly one entry with data 0, break tag 1, framing tag 1 and parity tag 0. An all-zero frame whose low level ends before that limit is pushed as an ordinary framing-error character.
- R5: After a break, no character is accepted until the line has been sampled high on two consecutive ticks and a valid start bit follows. A single high sample does not end the wait.
- R6: The break tag of an entry shows in `lsr_q[4]` only once that entry is at the head of the queue. Entries queued behind the head do not affect the status bits.
- R7: A pulse on `lsr_rd` clears the sticky status bits `lsr_q[1]` (overrun), `lsr_q[2]` (parity), `lsr_q[3]` (framing) and `lsr_q[4]` (break). `lsr_q[0]` (data ready = queue not empty) is not affected.
- R8: The queue holds 16 entries and returns them in arrival order. A character that arrives while the queue is full is dropped, and it sets `lsr_q[1]`.
- R9: A low pulse shorter than half a bit time is rejected as a glitch and queues nothing.
- R10: After reset, `lsr_q` is 0 (break bit included) and `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, already synchronised to clk |
| cfg_len | input | 2 | Data length code: 0 to 3 means 5 to 8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| rx_pop | input | 1 | Remove the head entry (ignored when the queue is empty) |
| rx_data | output | 8 | Data of the head entry |
| rx_valid | output | 1 | Queue not empty |
| lsr_rd | input | 1 | Status read strobe; clears the sticky bits |
| lsr_q | output | 5 | {break, framing, parity, overrun, ready} |

## Verification
The assertions assume the following about the inputs:
- `rxd` is already synchronous to `clk`.
- `sample_tick` is a single-cycle pulse.
- The configuration inputs change only while the line is idle between frames.
- `rx_pop` and `lsr_rd` are single-cycle strobes.

The stimulus respects all of these. It changes the configuration only after the trailing idle time of each frame, and it drives the line, the strobes and the tick on falling clock edges. Edges of the line therefore never coincide with the sampling edge. The glitch and marking tests use low and high times that are whole tick periods, so that exactly the intended number of samples lands in each level.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int OSR = 16;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD, ST_BWAIT
  } rx_state_t;

  // sample ticks in one full character at the given settings
  function automatic logic [7:0] frame_ticks(logic [1:0] len_code, logic par_en,
                                             logic two_stop);
    int unsigned b;
    b = 7 + int'(len_code) + int'(par_en) + int'(two_stop);
    return 8'(b * OSR);
  endfunction

  function automatic logic parity_bit(logic [7:0] d, logic odd);
    return (^d) ^ odd;
  endfunction

  // bits arrive LSB first into the top of the shifter
  function automatic logic [7:0] align(logic [7:0] sh, logic [1:0] len_code);
    return sh >> (2'd3 - len_code);
  endfunction
endpackage

// File: rtl/rxb_frame.sv
module rxb_frame
  import rxb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic [1:0] len_code,
  input  logic      par_en,
  input  logic      par_odd,
  input  logic      two_stop,
  output logic      push,
  output rx_entry_t push_entry
);
  localparam int TW = $clog2(OSR);
  localparam logic [TW-1:0] MID  = TW'(OSR / 2 - 1);
  localparam logic [TW-1:0] LAST = TW'(OSR - 1);

  rx_state_t     state;
  logic [TW-1:0] tcnt;
  logic [2:0]    bidx;
  logic [7:0]    sh, low_cnt;
  logic          all_low, perr_q, ferr_q, stop2, mk;

  logic [7:0] limit, word;
  logic       mid_hit, glitch, brk_fire, mark_done;

  assign limit     = frame_ticks(len_code, par_en, two_stop);
  assign word      = align(sh, len_code);
  assign mid_hit   = tick && state == ST_START && tcnt == MID;
  assign glitch    = mid_hit && rxd;
  assign brk_fire  = tick && state == ST_HOLD && !rxd && low_cnt >= limit;
  assign mark_done = tick && state == ST_BWAIT && rxd && mk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tcnt       <= '0;
      bidx       <= '0;
      sh         <= '0;
      low_cnt    <= '0;
      all_low    <= 1'b0;
      perr_q     <= 1'b0;
      ferr_q     <= 1'b0;
      stop2      <= 1'b0;
      mk         <= 1'b0;
      push       <= 1'b0;
      push_entry <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        low_cnt <= rxd ? 8'd0 : ((&low_cnt) ? low_cnt : low_cnt + 8'd1);
        tcnt    <= tcnt + 1'b1;
        unique case (state)
          ST_IDLE: begin
            if (!rxd) begin
              state <= ST_START;
              tcnt  <= TW'(1);
            end else begin
              tcnt <= '0;
            end
          end
          ST_START: begin
            if (tcnt == MID) begin
              if (rxd) begin
                state <= ST_IDLE;
              end else begin
                state   <= ST_DATA;
                tcnt    <= '0;
                bidx    <= '0;
                sh      <= '0;
                all_low <= 1'b1;
                perr_q  <= 1'b0;
                ferr_q  <= 1'b0;
                stop2   <= 1'b0;
              end
            end
          end
          ST_DATA: begin
            if (tcnt == LAST) begin
              sh      <= {rxd, sh[7:1]};
              all_low <= all_low & !rxd;
              if (bidx == {1'b1, len_code}) begin
                state <= par_en ? ST_PAR : ST_STOP;
              end else begin
                bidx <= bidx + 3'd1;
              end
            end
          end
          ST_PAR: begin
            if (tcnt == LAST) begin
              perr_q  <= rxd != parity_bit(word, par_odd);
              all_low <= all_low & !rxd;
              state   <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (tcnt == LAST) begin
              if (two_stop && !stop2) begin
                stop2   <= 1'b1;
                ferr_q  <= ferr_q | !rxd;
                all_low <= all_low & !rxd;
              end else if (all_low && !rxd) begin
                state <= ST_HOLD;
              end else begin
                push       <= 1'b1;
                push_entry <= '{1'b0, ferr_q | !rxd, perr_q, word};
                state      <= ST_IDLE;
              end
            end
          end
          ST_HOLD: begin
            if (rxd) begin
              push       <= 1'b1;
              push_entry <= '{1'b0, 1'b1, perr_q, word};
              state      <= ST_IDLE;
            end else if (brk_fire) begin
              push       <= 1'b1;
              push_entry <= '{1'b1, 1'b1, 1'b0, 8'h00};
              state      <= ST_BWAIT;
              mk         <= 1'b0;
            end
          end
          ST_BWAIT: begin
            if (rxd) begin
              if (mark_done) state <= ST_IDLE;
              mk <= 1'b1;
            end else begin
              mk <= 1'b0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    glitch |=> state == ST_IDLE && !push); // R9
  AST_BWAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BWAIT && $past(state) == ST_BWAIT) |-> !push); // R5
  AST_MARK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_BWAIT && state != ST_BWAIT) |-> $past(rxd) && $past(mk)); // R5
  AST_BRK_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_entry.brk) |-> $past(state) == ST_HOLD && !$past(rxd)
                                 && $past(low_cnt) >= $past(limit)); // R4
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign full    = count == CW'(DEPTH);
  assign empty   = count == '0;
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign drop    = push && full;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count)); // R8
endmodule

// File: rtl/rxb_status.sv
module rxb_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       empty,
  input  logic       pop,
  input  logic       drop,
  input  logic       lsr_rd,
  input  logic [2:0] head_tags,  // {brk, ferr, perr}
  output logic [4:0] lsr
);
  logic prev_empty, prev_pop, load;
  logic brk_q, ferr_q, perr_q, ovr_q;

  // a new entry has just become the head
  assign load = !empty && (prev_empty || prev_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_empty <= 1'b1;
      prev_pop   <= 1'b0;
      brk_q      <= 1'b0;
      ferr_q     <= 1'b0;
      perr_q     <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      prev_empty <= empty;
      prev_pop   <= pop && !empty;
      brk_q      <= (brk_q  && !lsr_rd) || (load && head_tags[2]);
      ferr_q     <= (ferr_q && !lsr_rd) || (load && head_tags[1]);
      perr_q     <= (perr_q && !lsr_rd) || (load && head_tags[0]);
      ovr_q      <= (ovr_q  && !lsr_rd) || drop;
    end
  end

  assign lsr = {brk_q, ferr_q, perr_q, ovr_q, !empty};

  AST_BRK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !load) |=> !brk_q); // R7
  AST_BRK_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_q) |-> $past(!empty) && $past(head_tags[2])); // R6
endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk
  import rxb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       rx_pop,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       lsr_rd,
  output logic [4:0] lsr_q
);
  localparam int EW = $bits(rx_entry_t);

  logic      push, empty, full, drop;
  rx_entry_t push_entry, head;
  logic [EW-1:0] head_vec;

  rxb_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sample_tick),
    .rxd       (rxd),
    .len_code  (cfg_len),
    .par_en    (cfg_par_en),
    .par_odd   (cfg_par_odd),
    .two_stop  (cfg_two_stop),
    .push      (push),
    .push_entry(push_entry)
  );

  rxb_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push),
    .pop  (rx_pop),
    .din  (push_entry),
    .head (head_vec),
    .empty(empty),
    .full (full),
    .drop (drop)
  );

  assign head = head_vec;

  rxb_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .empty    (empty),
    .pop      (rx_pop),
    .drop     (drop),
    .lsr_rd   (lsr_rd),
    .head_tags({head.brk, head.ferr, head.perr}),
    .lsr      (lsr_q)
  );

  assign rx_data  = head.data;
  assign rx_valid = !empty;

  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> rx_valid); // R8
endmodule

// File: tb/sim_serial_rx_brk.sv
module sim_serial_rx_brk;
  localparam int BITCLK = 32;  // tick every other clock, 16 ticks per bit

  logic clk = 0, rst_n = 0, sample_tick = 0, rxd = 1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0;
  logic rx_pop = 0, lsr_rd = 0;
  logic [7:0] rx_data;
  logic rx_valid;
  logic [4:0] lsr_q;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;
  always @(negedge clk) sample_tick <= ~sample_tick;

  serial_rx_brk u0 (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_valid(rx_valid), .lsr_rd(lsr_rd), .lsr_q(lsr_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask(input int len);
    return 8'hFF >> (8 - len);
  endfunction

  task automatic line(input logic v, input int clocks);
    rxd = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic setcfg(input int len, input int pm, input bit two);
    cfg_len      = 2'(len - 5);
    cfg_par_en   = (pm != 0);
    cfg_par_odd  = (pm == 2);
    cfg_two_stop = two;
    repeat (2) @(negedge clk);
  endtask

  // pm: 0 none, 1 even, 2 odd
  task automatic send(input logic [7:0] d, input int len, input int pm, input bit two,
                      input bit badp, input bit s1_low, input bit s2_low);
    logic p;
    line(1'b0, BITCLK);
    for (int i = 0; i < len; i++) line(d[i], BITCLK);
    if (pm != 0) begin
      p = ^(d & mask(len));
      if (pm == 2) p = ~p;
      if (badp) p = ~p;
      line(p, BITCLK);
    end
    if (s1_low) begin line(1'b0, 20); line(1'b1, BITCLK - 20); end
    else line(1'b1, BITCLK);
    if (two) begin
      if (s2_low) begin line(1'b0, 20); line(1'b1, BITCLK - 20); end
      else line(1'b1, BITCLK);
    end
    line(1'b1, 2 * BITCLK);
  endtask

  task automatic take(input string req, input logic [7:0] ed, input logic [4:0] el, input bit clr);
    chk({req, " data"}, rx_data, ed);
    chk({req, " status"}, lsr_q, el);
    rx_pop = 1; lsr_rd = clr;
    @(negedge clk);
    rx_pop = 0; lsr_rd = 0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] pick(input int k, input int lc, input int pm, input int ts);
    case (k)
      0: return 8'hA5;
      1: return 8'h3C;
      2: return 8'hFF;
      default: return 8'((lc * 29 + pm * 11 + ts * 3 + 67) & 255);
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R10 status in reset", lsr_q, 5'b00000);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R10 status after reset", lsr_q, 5'b00000);
    chk("R10 valid after reset", rx_valid, 0);

    // R1 / R2: sweep every length, parity mode and stop count
    for (int lc = 0; lc < 4; lc++)
      for (int pm = 0; pm < 3; pm++)
        for (int ts = 0; ts < 2; ts++) begin
          setcfg(lc + 5, pm, ts[0]);
          for (int k = 0; k < 4; k++) begin
            send(pick(k, lc, pm, ts), lc + 5, pm, ts[0], 0, 0, 0);
            take("R1 sweep", pick(k, lc, pm, ts) & mask(lc + 5), 5'b00001, 1);
          end
          if (pm != 0) begin
            send(8'h6B, lc + 5, pm, ts[0], 1, 0, 0);
            take("R2 bad parity", 8'h6B & mask(lc + 5), 5'b00101, 1);
          end
        end

    // R3 framing, one and two stop bits
    setcfg(8, 0, 0);
    send(8'h55, 8, 0, 0, 0, 1, 0);
    take("R3 low stop", 8'h55, 5'b01001, 1);
    setcfg(7, 1, 1);
    send(8'h2B, 7, 1, 1, 0, 0, 1);
    take("R3 low second stop", 8'h2B, 5'b01001, 1);

    // R4 all-zero frame shorter than the limit is not a break
    setcfg(8, 0, 0);
    send(8'h00, 8, 0, 0, 0, 1, 0);
    take("R4 short low", 8'h00, 5'b01001, 1);
    chk("R4 short low single", rx_valid, 0);

    // R4 long break, 8N1
    line(1'b0, 30 * BITCLK);
    line(1'b1, 4 * BITCLK);
    take("R4 break 8N1", 8'h00, 5'b11001, 1);
    chk("R4 one break entry", rx_valid, 0);

    // R4 break with odd parity and two stop bits: parity tag stays 0
    setcfg(5, 2, 1);
    line(1'b0, 12 * BITCLK);
    line(1'b1, 4 * BITCLK);
    take("R4 break 5O2", 8'h00, 5'b11001, 1);
    chk("R4 one break entry 5O2", rx_valid, 0);

    // R5 a single high sample does not end the wait after a break
    setcfg(8, 0, 0);
    line(1'b0, 20 * BITCLK);
    line(1'b1, 2);
    line(1'b0, 40 * BITCLK);
    line(1'b1, 4 * BITCLK);
    take("R5 break entry", 8'h00, 5'b11001, 1);
    chk("R5 no extra entry", rx_valid, 0);
    send(8'h5A, 8, 0, 0, 0, 0, 0);
    take("R5 resumes", 8'h5A, 5'b00001, 1);

    // R6 break tag shows only at the head; R7 clear on read
    send(8'h11, 8, 0, 0, 0, 0, 0);
    line(1'b0, 15 * BITCLK);
    line(1'b1, 3 * BITCLK);
    take("R6 plain head first", 8'h11, 5'b00001, 1);
    chk("R6 break at head", lsr_q, 5'b11001);
    chk("R6 break data", rx_data, 8'h00);
    lsr_rd = 1; @(negedge clk); lsr_rd = 0;
    repeat (2) @(negedge clk);
    chk("R7 break cleared by read", lsr_q, 5'b00001);
    rx_pop = 1; @(negedge clk); rx_pop = 0;
    repeat (3) @(negedge clk);
    chk("R6 queue empty", rx_valid, 0);

    // R9 glitch rejection
    line(1'b0, 12);
    line(1'b1, 20 * BITCLK);
    chk("R9 glitch valid", rx_valid, 0);
    chk("R9 glitch status", lsr_q, 5'b00000);

    // R8 overrun: seventeen characters into sixteen entries
    for (int i = 0; i < 17; i++) send(8'(i * 13 + 1), 8, 0, 0, 0, 0, 0);
    chk("R8 overrun flag", lsr_q, 5'b00011);
    for (int i = 0; i < 16; i++) take("R8 order", 8'(i * 13 + 1), 5'b00011, 0);
    chk("R8 drained", rx_valid, 0);
    chk("R8 overrun kept", lsr_q, 5'b00010);
    lsr_rd = 1; @(negedge clk); lsr_rd = 0;
    repeat (2) @(negedge clk);
    chk("R7 overrun cleared", lsr_q, 5'b00000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule